// File: doc/BRIEF.md
# NRZI Packet Framer with Bit Destuffing

This block sits behind a line-symbol classifier and a timing-recovery stage on a low-speed or full-speed USB receiver. Each time the recovery stage strobes a sample point it hands over one two-bit line symbol. The block finds the start of a packet, turns symbol-to-symbol transitions into data bits, strips the stuff bit that the sender inserts after every run of six ones, and checks the single-ended-zero-then-J ending of the packet.

All outputs are combinational pulses that are valid in the same cycle as the strobe that caused them. The state moves forward at the clock edge that ends that cycle. A decoded-zero flag marks every transition-carrying sample, stuff bits included, so that the recovery stage can re-centre its sampling on edges. The block also watches the first sixteen data bits of each packet. When they form a sync field followed by the low-speed preamble identifier, it drops the packet and raises a preamble pulse, so that the surrounding logic can switch to the low-speed rate.

Symbol codes at `sym`: 2'b00 single-ended zero (SE0), 2'b01 J, 2'b10 K, 2'b11 single-ended one (SE1).

Top module: `nrzi_unstuff`

## Requirements
- R1: While idle, a strobe that carries K when the previous strobe carried J raises `sop` and delivers data bit 0 (`dat_vld`=1, `dat_bit`=0) in the same cycle, because the previous symbol counts as J.
- R2: Inside a packet, each non-SE0 strobe decodes to 1 when its symbol equals the previous strobe's symbol and to 0 when it differs. Data bits appear in the order they are received.
- R3: After six delivered 1 bits in a row, the next strobe with a changed symbol is a stuff bit. It raises `stuff` and does not raise `dat_vld`. Any 0, stuff bits included, restarts the count of ones.
- R4: If the symbol stays unchanged in the stuff position, `stuff_err` pulses and the block goes idle. A later packet start then needs a J strobe before its K.
- R5: A strobe with SE0 inside a packet delivers no bit and starts the end of the packet. Any number of SE0 strobes may follow. The first J after them raises `eop` and leaves the block idle with J as the last symbol, so the next K starts a new packet.
- R6: A K or SE1 strobe after the SE0 raises `eop_err` and leaves the block idle. A J strobe is then needed before a new start.
- R7: If the first 16 delivered data bits, in arrival order, are 0000000100111100, then `pre` pulses on the strobe of the 16th bit, which is itself delivered. The packet is dropped and the block goes idle with J as the last symbol.
- R8: `zero` pulses on every strobe that decodes a 0, whether it is a data bit or a stuff bit.
- R9: A cycle with `sym_vld` low produces no output pulse and does not change the decoding state, whatever `sym` carries.
- R10: At most one of `sop`, `stuff`, `stuff_err`, `eop`, `eop_err`, `pre` is high in any cycle.
- R11: After reset the block is idle with no previous symbol and every output is low. A K strobe must therefore follow a J strobe before it can start a packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_vld | input | 1 | Sample strobe; `sym` is taken only while high |
| sym | input | 2 | Line symbol: 00 SE0, 01 J, 10 K, 11 SE1 |
| sop | output | 1 | Start-of-packet pulse |
| dat_vld | output | 1 | A decoded data bit is on `dat_bit` |
| dat_bit | output | 1 | Decoded data bit |
| stuff | output | 1 | A stuff bit was removed |
| zero | output | 1 | This sample decoded to 0 (data or stuff) |
| stuff_err | output | 1 | Bit-stuffing violation, packet aborted |
| eop | output | 1 | Valid end of packet |
| eop_err | output | 1 | Malformed end of packet |
| pre | output | 1 | Sync plus low-speed preamble detected |

## Verification
The main sweep encodes every possible first payload byte, followed by an all-ones byte, through an NRZI encoder and stuffer inside the bench. It then compares the delivered bits and the counts of stuff bits, zeros and endings. This separates correct transition decoding from inverted decoding, and a stuff bit that is removed from one that is leaked or missed. The one byte value that completes the preamble pattern must give `pre` and no `eop`. Directed packets cover a seventh unchanged symbol, a K after SE0, a long SE0, a start right after reset, and symbols that change while the strobe is low. Each of these tells whether the block re-arms only after a J and whether unstrobed cycles leave it untouched.

// File: rtl/nrzi_unstuff.sv
module nrzi_unstuff #(
  parameter int ONES_MAX = 6,
  parameter int PRE_BITS = 16,
  parameter logic [PRE_BITS-1:0] PRE_CODE = 16'h013C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_vld,
  input  logic [1:0] sym,
  output logic       sop,
  output logic       dat_vld,
  output logic       dat_bit,
  output logic       stuff,
  output logic       zero,
  output logic       stuff_err,
  output logic       eop,
  output logic       eop_err,
  output logic       pre
);
  localparam int OW = $clog2(ONES_MAX + 1);
  localparam int CW = $clog2(PRE_BITS + 1);
  localparam logic [1:0] SYM_SE0 = 2'b00;
  localparam logic [1:0] SYM_J   = 2'b01;
  localparam logic [1:0] SYM_K   = 2'b10;
  localparam logic [1:0] SYM_SE1 = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_EOP} st_t;

  st_t st, st_n;
  logic [1:0] prv, prv_n;
  logic [OW-1:0] ones, ones_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [PRE_BITS-1:0] shr, shr_n;

  wire same = (sym == prv);

  always_comb begin
    st_n = st; prv_n = prv; ones_n = ones; cnt_n = cnt; shr_n = shr;
    sop = 1'b0; dat_vld = 1'b0; dat_bit = 1'b0; stuff = 1'b0; zero = 1'b0;
    stuff_err = 1'b0; eop = 1'b0; eop_err = 1'b0; pre = 1'b0;
    if (sym_vld) begin
      case (st)
        S_IDLE: begin
          prv_n = sym;
          if (prv == SYM_J && sym == SYM_K) begin
            sop = 1'b1; dat_vld = 1'b1; zero = 1'b1;
            st_n = S_DATA; ones_n = '0; cnt_n = CW'(1); shr_n = '0;
          end
        end
        S_DATA: begin
          if (sym == SYM_SE0) begin
            st_n = S_EOP;
          end else begin
            prv_n = sym;
            if (ones == OW'(ONES_MAX)) begin
              if (same) begin
                stuff_err = 1'b1; st_n = S_IDLE; prv_n = SYM_SE1;
              end else begin
                stuff = 1'b1; zero = 1'b1; ones_n = '0;
              end
            end else begin
              dat_vld = 1'b1; dat_bit = same; zero = !same;
              ones_n = same ? ones + OW'(1) : '0;
              if (cnt < CW'(PRE_BITS)) begin
                shr_n = {shr[PRE_BITS-2:0], same};
                cnt_n = cnt + CW'(1);
                if (cnt == CW'(PRE_BITS - 1) && shr_n == PRE_CODE) begin
                  pre = 1'b1; st_n = S_IDLE; prv_n = SYM_J;
                end
              end
            end
          end
        end
        S_EOP: begin
          if (sym == SYM_J) begin
            eop = 1'b1; st_n = S_IDLE; prv_n = SYM_J;
          end else if (sym != SYM_SE0) begin
            eop_err = 1'b1; st_n = S_IDLE; prv_n = SYM_SE1;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; prv <= SYM_SE1; ones <= '0; cnt <= '0; shr <= '0;
    end else begin
      st <= st_n; prv <= prv_n; ones <= ones_n; cnt <= cnt_n; shr <= shr_n;
    end
  end

  logic [OW-1:0] chk_ones;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_ones <= '0;
    else if (sop || stuff) chk_ones <= '0;
    else if (dat_vld) chk_ones <= !dat_bit ? '0 :
                                 (chk_ones == OW'(ONES_MAX)) ? chk_ones : chk_ones + OW'(1);
  end

  assert_stuff_after_six_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stuff |-> chk_ones == OW'(ONES_MAX));
  assert_no_seventh_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_vld && !sop) |-> chk_ones < OW'(ONES_MAX));
  assert_err_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_err || eop_err) |=> !sop);
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_vld && !dat_bit) || stuff) |-> zero);
  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sop, stuff, stuff_err, eop, eop_err, pre}));
endmodule

// File: tb/nrzi_unstuff_tb.sv
module nrzi_unstuff_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_vld = 1'b0;
  logic [1:0] sym = 2'b01;
  logic sop, dat_vld, dat_bit, stuff, zero, stuff_err, eop, eop_err, pre;

  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

  always #10 clk = ~clk;

  nrzi_unstuff u_dut (.clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym(sym),
    .sop(sop), .dat_vld(dat_vld), .dat_bit(dat_bit), .stuff(stuff), .zero(zero),
    .stuff_err(stuff_err), .eop(eop), .eop_err(eop_err), .pre(pre));

  int checks = 0, errors = 0;
  int n_sop, n_stuff, n_zero, n_serr, n_eop, n_eerr, n_pre, n_multi, n_gap;
  logic rx_b [0:63];
  logic ex_b [0:63];
  int rx_n, ex_n, ex_stuff, ex_zero, ones;
  logic [1:0] cur;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_sop = 0; n_stuff = 0; n_zero = 0; n_serr = 0; n_eop = 0; n_eerr = 0;
    n_pre = 0; n_multi = 0; n_gap = 0; rx_n = 0; ex_n = 0; ex_stuff = 0;
    ex_zero = 0; ones = 0; cur = J;
  endtask

  task automatic tx(input logic [1:0] s);
    @(negedge clk); sym = s; sym_vld = 1'b1; #1;
    if (dat_vld && rx_n < 64) begin rx_b[rx_n] = dat_bit; rx_n++; end
    n_sop += int'(sop); n_stuff += int'(stuff); n_zero += int'(zero);
    n_serr += int'(stuff_err); n_eop += int'(eop); n_eerr += int'(eop_err);
    n_pre += int'(pre);
    if (int'(sop) + int'(stuff) + int'(stuff_err) + int'(eop) + int'(eop_err) + int'(pre) > 1)
      n_multi++;
  endtask

  task automatic gap(input logic [1:0] s);
    @(negedge clk); sym = s; sym_vld = 1'b0; #1;
    n_gap += int'(sop) + int'(dat_vld) + int'(stuff) + int'(zero) + int'(stuff_err)
           + int'(eop) + int'(eop_err) + int'(pre);
  endtask

  task automatic enc(input logic b);
    if (!b) cur = (cur == J) ? K : J;
    tx(cur);
    if (ex_n < 64) begin ex_b[ex_n] = b; ex_n++; end
    if (b) ones++; else begin ones = 0; ex_zero++; end
    if (ones == 6) begin
      cur = (cur == J) ? K : J;
      tx(cur); ones = 0; ex_stuff++; ex_zero++;
    end
  endtask

  task automatic sync();
    for (int i = 0; i < 7; i++) enc(1'b0);
    enc(1'b1);
  endtask

  task automatic byte_out(input logic [7:0] v);
    for (int i = 0; i < 8; i++) enc(v[i]);
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < 64; i++) if (i < ex_n && rx_b[i] !== ex_b[i]) m++;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check({sop, dat_vld, stuff, zero, stuff_err, eop, eop_err, pre} == 8'h0, "R11 reset outputs",
          {sop, dat_vld, stuff, zero, stuff_err, eop, eop_err, pre}, 0);
    rst_n = 1'b1;

    // R11: K right after reset does not start; J then K does
    clr(); tx(K); tx(K);
    check(n_sop == 0, "R11 no start without J", n_sop, 0);
    tx(J); tx(K);
    check(n_sop == 1 && rx_n == 1 && rx_b[0] == 1'b0, "R1 start on J-K with bit 0", n_sop, 1);
    tx(SE0); tx(J);
    check(n_eop == 1 && rx_n == 1, "R5 short end", n_eop, 1);

    // Sweep: every first payload byte, then all ones (R2 R3 R5 R7 R8 R10)
    for (int v = 0; v < 256; v++) begin
      clr(); tx(J);
      sync(); byte_out(8'(v));
      if (v == 8'h3C) begin
        tx(J);
        check(n_pre == 1 && n_eop == 0, "R7 preamble pulse", n_pre, 1);
        check(rx_n == 16 && mism() == 0, "R7 bits before preamble", rx_n, 16);
      end else begin
        byte_out(8'hFF);
        tx(SE0); tx(SE0); tx(J);
        check(rx_n == ex_n && mism() == 0, "R2 decoded bits", rx_n, ex_n);
        check(n_stuff == ex_stuff, "R3 stuff count", n_stuff, ex_stuff);
        check(n_zero == ex_zero, "R8 zero count", n_zero, ex_zero);
        check(n_eop == 1 && n_pre == 0 && n_serr == 0 && n_eerr == 0, "R5 clean end", n_eop, 1);
      end
      check(n_sop == 1 && n_multi == 0, "R10 single event per strobe", n_multi, 0);
    end

    // R4: seventh unchanged symbol aborts, re-arm needs J
    clr(); tx(J); sync();
    for (int i = 0; i < 5; i++) tx(cur);
    check(n_serr == 0 && rx_n == 13, "R4 six ones delivered", rx_n, 13);
    tx(cur);
    check(n_serr == 1 && rx_n == 13, "R4 stuff error", n_serr, 1);
    tx(K);
    check(n_sop == 1, "R4 no start without J", n_sop, 1);
    tx(J); tx(K);
    check(n_sop == 2, "R4 start after J", n_sop, 2);
    tx(SE0); tx(J);

    // R6: K after SE0
    clr(); tx(J); sync(); tx(SE0); tx(K);
    check(n_eerr == 1 && n_eop == 0, "R6 end error", n_eerr, 1);
    tx(K);
    check(n_sop == 1, "R6 no start without J", n_sop, 1);
    tx(J);

    // R5: long SE0, then immediate new start
    clr(); tx(J); sync(); byte_out(8'hA5);
    for (int i = 0; i < 4; i++) tx(SE0);
    check(rx_n == 16 && n_eop == 0, "R5 no bits during SE0", rx_n, 16);
    tx(J);
    check(n_eop == 1 && mism() == 0, "R5 valid end", n_eop, 1);
    tx(K);
    check(n_sop == 2, "R5 start right after end", n_sop, 2);
    tx(SE0); tx(J);

    // R9: strobe low leaves outputs quiet and state unchanged
    clr(); tx(J); sync();
    gap(SE0); gap(K); gap(J); gap(2'b11); gap(SE0);
    check(n_gap == 0, "R9 no pulses while strobe low", n_gap, 0);
    byte_out(8'h5A); tx(SE0); tx(J);
    check(rx_n == 16 && mism() == 0 && n_eop == 1 && n_serr == 0, "R9 decoding unaffected", rx_n, 16);

    @(negedge clk); sym_vld = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule